// File: doc/BRIEF.md
# Bug Detection Checking Tree Node

This block is one node of a checking tree that turns per-segment match/mismatch indications into identifiers of detected design bugs. Its input vector carries one bit per child: a leaf node sees the results of eight-bit detection segments, so eight children cover 64 control flip-flops. A higher node sees the flags of lower nodes instead. Each input bit is 0 when the child reports a match and 1 when it reports a mismatch.

The node holds a small table that is programmed at run time, normally once at start-up. Each entry has a valid bit, a bug identifier and a three-valued pattern over the inputs. The pattern is stored per position as a care bit and an expected bit; a position whose care bit is 0 is a don't-care. In every cycle all entries are compared with the input vector in parallel. When one or more valid entries are satisfied, the lowest-numbered one wins, and its identifier goes to the parent together with a flag set to 1. The result is registered, so each tree level adds one cycle. At the root, the flag is the global bug detection signal that starts system recovery.

Top module: `bug_tree_node`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hit_flag` is 0 and `hit_id` is 0. Reset clears the valid bit of every table entry, so no input pattern hits until an entry has been written again.
- R2: A valid entry whose care bits are all 1 hits only when `in_vec` equals its expected bits exactly. The resulting `hit_flag`=1 and `hit_id`=entry identifier appear at the first rising edge after that input is presented.
- R3: Input positions whose care bit is 0 do not affect whether an entry hits.
- R4: An entry written with `wr_valid`=0 never produces a hit, even if its pattern is all don't-care.
- R5: When several valid entries hit in the same cycle, the entry with the lowest index is reported.
- R6: When no valid entry hits, the next output is `hit_flag`=0 and `hit_id`=0.
- R7: Asserting `wr_en` at a rising edge replaces entry `wr_addr` entirely (valid, identifier, care, expected). The lookup at that same edge still uses the old contents, and the new contents apply from the next edge on.
- R8: The output is re-evaluated at every edge with no hold, so back-to-back input vectors each give their own result exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | AW ($clog2(N_ENT)) | Entry index to write |
| wr_valid | input | 1 | Valid bit of the written entry |
| wr_id | input | ID_W | Bug identifier of the written entry |
| wr_care | input | N_IN | Care bits (1 = position is compared) |
| wr_expect | input | N_IN | Expected input value for cared positions |
| in_vec | input | N_IN | Child match (0) / mismatch (1) indications |
| hit_flag | output | 1 | Registered: some valid entry hit |
| hit_id | output | ID_W | Registered identifier of the winning entry, 0 when no hit |

## Verification
Every lookup result is due exactly one rising edge after its input vector is applied. A table write takes effect for inputs applied one edge after the write edge. The bench drives inputs on falling edges and tags each expected result with the cycle count at which it becomes due. The monitor compares the result on the falling edge of that cycle. This lets back-to-back vectors, and a write issued in the same cycle as a lookup, be checked against the old and then the new table contents with no timing slack.

// File: rtl/bug_tree_node.sv
module bug_tree_node #(
  parameter  int N_IN  = 8,
  parameter  int N_ENT = 16,
  parameter  int ID_W  = 8,
  localparam int AW    = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic            wr_valid,
  input  logic [ID_W-1:0] wr_id,
  input  logic [N_IN-1:0] wr_care,
  input  logic [N_IN-1:0] wr_expect,
  input  logic [N_IN-1:0] in_vec,
  output logic            hit_flag,
  output logic [ID_W-1:0] hit_id
);

  logic [N_ENT-1:0] valid_q;
  logic [ID_W-1:0]  id_q   [N_ENT];
  logic [N_IN-1:0]  care_q [N_ENT];
  logic [N_IN-1:0]  exp_q  [N_ENT];
  logic [N_ENT-1:0] hit_vec;
  logic             any_hit;
  logic [ID_W-1:0]  win_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_addr] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      id_q[wr_addr]   <= wr_id;
      care_q[wr_addr] <= wr_care;
      exp_q[wr_addr]  <= wr_expect;
    end
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    assign hit_vec[e] = valid_q[e] & ~|(care_q[e] & (in_vec ^ exp_q[e]));
  end

  always_comb begin
    any_hit = 1'b0;
    win_id  = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_id  = id_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_flag <= 1'b0;
      hit_id   <= '0;
    end else begin
      hit_flag <= any_hit;
      hit_id   <= win_id;
    end
  end

endmodule

module bug_tree_node_chk #(
  parameter int N_ENT = 16,
  parameter int ID_W  = 8,
  parameter int AW    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_valid,
  input logic [AW-1:0]   wr_addr,
  input logic [N_ENT-1:0] valid_q,
  input logic [N_ENT-1:0] hit_vec,
  input logic            hit_flag,
  input logic [ID_W-1:0] hit_id
);

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) reset_clear_chk: assert (!hit_flag && hit_id == '0 && valid_q == '0);
  end

  // R6
  idle_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_flag |-> hit_id == '0);

  // R2
  flag_follows_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> hit_flag == $past(|hit_vec));

  // R4
  empty_table_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q == '0 |=> !hit_flag);

  // R7
  write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_addr)] == $past(wr_valid));

endmodule

bind bug_tree_node bug_tree_node_chk #(.N_ENT(N_ENT), .ID_W(ID_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .valid_q(valid_q), .hit_vec(hit_vec), .hit_flag(hit_flag), .hit_id(hit_id)
);

// File: tb/bug_tree_node_bench.sv
module bug_tree_node_bench;
  localparam int N_IN = 8, N_ENT = 16, ID_W = 8, AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic wr_en = 1'b0, wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [ID_W-1:0] wr_id = '0;
  logic [N_IN-1:0] wr_care = '0, wr_expect = '0, in_vec = '0;
  logic hit_flag;
  logic [ID_W-1:0] hit_id;

  int checks = 0, errors = 0;
  longint cyc = 0;
  bit done = 1'b0;

  bit [ID_W:0] exp_q[$];
  string tag_q[$];
  longint due_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bug_tree_node #(.N_IN(N_IN), .N_ENT(N_ENT), .ID_W(ID_W)) u_bug_tree_node (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_valid(wr_valid),
    .wr_id(wr_id), .wr_care(wr_care), .wr_expect(wr_expect), .in_vec(in_vec),
    .hit_flag(hit_flag), .hit_id(hit_id));

  task automatic compare(input string tag, input bit ef, input bit [ID_W-1:0] eid);
    checks++;
    if (hit_flag !== ef || hit_id !== eid) begin
      errors++;
      $display("FAIL %s: got flag=%0b id=%02h, expected flag=%0b id=%02h",
               tag, hit_flag, hit_id, ef, eid);
    end
  endtask

  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      bit [ID_W:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      void'(due_q.pop_front());
      compare(t, e[ID_W], e[ID_W-1:0]);
    end
  end

  task automatic prog(input int a, input bit v, input bit [ID_W-1:0] id,
                      input bit [N_IN-1:0] care, input bit [N_IN-1:0] ex);
    wr_en = 1'b1; wr_addr = AW'(a); wr_valid = v;
    wr_id = id; wr_care = care; wr_expect = ex;
  endtask

  task automatic step(input bit [N_IN-1:0] v, input bit ef, input bit [ID_W-1:0] eid,
                      input string tag);
    @(negedge clk);
    in_vec = v;
    exp_q.push_back({ef, eid});
    tag_q.push_back(tag);
    due_q.push_back(cyc + 1);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1", 1'b0, 8'h00);
    rst_n = 1'b1;
    step(8'h00, 0, 8'h00, "R1");
    prog(5, 1, 8'h2A, 8'hFF, 8'h35); step(8'h00, 0, 8'h00, "R6");
    step(8'h35, 1, 8'h2A, "R2");
    step(8'h34, 0, 8'h00, "R6");
    prog(9, 1, 8'h51, 8'h0F, 8'h05); step(8'h00, 0, 8'h00, "R6");
    step(8'hA5, 1, 8'h51, "R3");
    step(8'hF5, 1, 8'h51, "R3");
    step(8'hA7, 0, 8'h00, "R6");
    step(8'h35, 1, 8'h2A, "R5");
    prog(2, 0, 8'h77, 8'h00, 8'h00); step(8'h00, 0, 8'h00, "R4");
    step(8'h5A, 0, 8'h00, "R4");
    prog(2, 1, 8'h77, 8'h00, 8'h00); step(8'h5A, 0, 8'h00, "R7");
    step(8'h5A, 1, 8'h77, "R7");
    step(8'h35, 1, 8'h77, "R5");
    prog(2, 0, 8'h77, 8'h00, 8'h00); step(8'h35, 1, 8'h77, "R7");
    step(8'h35, 1, 8'h2A, "R7");
    prog(15, 1, 8'hEE, 8'hFF, 8'hFF); step(8'h00, 0, 8'h00, "R6");
    step(8'hFF, 1, 8'hEE, "R2");
    prog(0, 1, 8'h01, 8'hFF, 8'h11); step(8'h11, 0, 8'h00, "R7");
    step(8'h11, 1, 8'h01, "R8");
    step(8'h35, 1, 8'h2A, "R8");
    step(8'hA5, 1, 8'h51, "R8");
    step(8'h11, 1, 8'h01, "R8");
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1 compare("R1", 1'b0, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    step(8'h35, 0, 8'h00, "R1");
    step(8'hFF, 0, 8'h00, "R1");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule